// File: doc/BRIEF.md
# Machine Counter and Timer Unit

This block keeps three free-running event counters for a processor core: elapsed clock cycles, retired instructions and wall time. Each counter is twice the register width (64 bits at the default 32-bit width). Software reads each counter one half at a time through a CSR read port. A count-inhibit register lets software pause the cycle counter and the retired-instruction counter separately. The time counter is never paused.

The unit also holds a timer-compare register, written in two halves. A comparator raises the machine timer interrupt whenever the time counter has reached the compare value. The trap logic that takes the interrupt sits outside this block.

CSR reads are combinational from the address. Writes take effect at the rising clock edge on which the write enable is sampled high. The core raises a retire pulse once per retired instruction.

Top module: `mctr_unit`

## Requirements
- R1: While the synchronous active-low reset is asserted, and on the first cycle after it is released, all counters read zero, the inhibit register reads zero, both compare halves read all ones and the interrupt output is low.
- R2: The cycle counter (low half at 0xC00, high half at 0xC80) advances by one on each clock edge at which inhibit bit 0 is clear, and holds its value while that bit is set.
- R3: The retired-instruction counter (low half at 0xC02, high half at 0xC82) advances by one on each clock edge at which the retire input is high and inhibit bit 2 is clear. Otherwise it holds.
- R4: The time counter (low half at 0xC01, high half at 0xC81) advances by one on every clock edge out of reset, whatever the inhibit register holds.
- R5: The inhibit register at 0x320 stores only bits 0 and 2 of a write. Every other bit always reads zero, so writing all ones reads back 0x5.
- R6: The timer-compare value is written and read at 0x321 (low half) and 0x322 (high half).
- R7: The interrupt output is high exactly when the unsigned time counter is greater than or equal to the unsigned compare value. It follows both registers in the same cycle.
- R8: When a counter's low half wraps from all ones to zero, its high half advances by one on the same edge.
- R9: A read from any address not listed in R2 to R6 returns zero. A write to such an address, or to a counter address, changes no state.
- R10: A write to the inhibit register changes counting from the clock edge after the write edge. The write edge itself still counts under the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_addr | input | 12 | CSR address for both read and write |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write enable, sampled on the rising edge |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| retire_i | input | 1 | One-cycle pulse per retired instruction |
| timer_irq_o | output | 1 | Machine timer interrupt request |

## Verification
The bench runs the unit at an 8-bit register width, so the counters are 16 bits wide and the carry from the low half into the high half appears within a few hundred cycles. Without a correct carry, the high half would stay at zero or jump at the wrong time.

The interrupt output is compared every cycle across the point where time passes the compare value. A comparator using strict greater-than would be one cycle late there. Writing the compare value low half first, while the high half is still all ones, shows whether the output glitches high in between.

Writing all ones to the inhibit register exposes reserved bits that are stored. Reads taken straight after an inhibit write catch a counter that freezes one edge too early or too late. Writes to unmapped addresses and to the read-only counter addresses would show up as a read-back change or a shifted count.

// File: rtl/mctr_pkg.sv
// Package: shared CSR map and counter indices for the machine counter unit.
// Assumes 12-bit CSR addresses. Counter index i has its halves at LO_BASE+i
// and HI_BASE+i, so the index order is fixed by the address map.
package mctr_pkg;

    localparam int          NCNT        = 3;
    localparam int          CNT_CYC     = 0;
    localparam int          CNT_TIM     = 1;
    localparam int          CNT_RET     = 2;

    localparam logic [11:0] CSR_LO_BASE = 12'hC00;
    localparam logic [11:0] CSR_HI_BASE = 12'hC80;
    localparam logic [11:0] CSR_INH     = 12'h320;
    localparam logic [11:0] CSR_CMP_LO  = 12'h321;
    localparam logic [11:0] CSR_CMP_HI  = 12'h322;

    localparam int          INH_CYC_BIT = 0;
    localparam int          INH_RET_BIT = 2;

    // True for any address that has a readable register behind it.
    function automatic logic csr_is_mapped(input logic [11:0] a);
        logic hit;
        hit = (a == CSR_INH) || (a == CSR_CMP_LO) || (a == CSR_CMP_HI);
        for (int i = 0; i < NCNT; i++) begin
            if (a == CSR_LO_BASE + 12'(i) || a == CSR_HI_BASE + 12'(i)) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/mctr_counter.sv
// Module: a double-width event counter held as two XLEN halves.
// Advances by one on each edge where en is high. The high half takes the
// carry when the low half wraps. Assumes a synchronous active-low reset.
module mctr_counter #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    output logic [XLEN-1:0] lo_o,
    output logic [XLEN-1:0] hi_o
);

    logic [XLEN-1:0] lo_q;
    logic [XLEN-1:0] hi_q;
    logic            lo_full;

    // Detect the low half at all ones, the point where a carry leaves it.
    always_comb begin
        lo_full = &lo_q;
    end

    // Count step: the low half always moves, the high half only on carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (en) begin
            lo_q <= lo_q + 1'b1;
            if (lo_full) begin
                hi_q <= hi_q + 1'b1;
            end
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    AST_CARRY_INTO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lo_full) |=> (hi_q == XLEN'($past(hi_q) + 1'b1)) && (lo_q == '0)); // R8

    AST_HI_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && lo_full) |=> $stable(hi_q)); // R8

endmodule

// File: rtl/mctr_regs.sv
// Module: software-written state. This is the count-inhibit register, of which
// only the cycle and retire bits are stored, and the two halves of the timer
// compare value. Assumes the caller qualifies writes with csr_we.
module mctr_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_we,
    output logic            inh_cyc_o,
    output logic            inh_ret_o,
    output logic [XLEN-1:0] cmp_lo_o,
    output logic [XLEN-1:0] cmp_hi_o
);
    import mctr_pkg::*;

    logic            wr_inh;
    logic            wr_cmp_lo;
    logic            wr_cmp_hi;
    logic            inh_cyc_q;
    logic            inh_ret_q;
    logic [XLEN-1:0] cmp_lo_q;
    logic [XLEN-1:0] cmp_hi_q;

    // Decode the write strobe for each register.
    always_comb begin
        wr_inh    = csr_we && (csr_addr == CSR_INH);
        wr_cmp_lo = csr_we && (csr_addr == CSR_CMP_LO);
        wr_cmp_hi = csr_we && (csr_addr == CSR_CMP_HI);
    end

    // Inhibit register: store only the two writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_cyc_q <= 1'b0;
            inh_ret_q <= 1'b0;
        end else if (wr_inh) begin
            inh_cyc_q <= csr_wdata[INH_CYC_BIT];
            inh_ret_q <= csr_wdata[INH_RET_BIT];
        end
    end

    // Compare register: each half is written on its own and resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_lo_q <= '1;
            cmp_hi_q <= '1;
        end else begin
            if (wr_cmp_lo) cmp_lo_q <= csr_wdata;
            if (wr_cmp_hi) cmp_hi_q <= csr_wdata;
        end
    end

    assign inh_cyc_o = inh_cyc_q;
    assign inh_ret_o = inh_ret_q;
    assign cmp_lo_o  = cmp_lo_q;
    assign cmp_hi_o  = cmp_hi_q;

    AST_CMP_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && (csr_addr == CSR_CMP_LO || csr_addr == CSR_CMP_HI))
        |=> $stable(cmp_lo_q) && $stable(cmp_hi_q)); // R9

    AST_INH_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && csr_addr == CSR_INH) |=> $stable(inh_cyc_q) && $stable(inh_ret_q)); // R9

endmodule

// File: rtl/mctr_cmp.sv
// Module: unsigned comparator for the timer interrupt. It compares the high
// halves first and uses the low halves to break a tie. Purely combinational.
// Assumes both inputs come straight from registers.
module mctr_cmp #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] tim_lo_i,
    input  logic [XLEN-1:0] tim_hi_i,
    input  logic [XLEN-1:0] cmp_lo_i,
    input  logic [XLEN-1:0] cmp_hi_i,
    output logic            irq_o
);

    logic hi_gt;
    logic hi_eq;
    logic lo_ge;

    // Greater-or-equal built from per-half results.
    always_comb begin
        hi_gt = tim_hi_i > cmp_hi_i;
        hi_eq = tim_hi_i == cmp_hi_i;
        lo_ge = tim_lo_i >= cmp_lo_i;
        irq_o = hi_gt || (hi_eq && lo_ge);
    end

    // Time only grows, so the request stays up unless the compare value moves or time wraps.
    AST_IRQ_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(&{tim_hi_i, tim_lo_i})) ##1 ($stable(cmp_lo_i) && $stable(cmp_hi_i))
        |-> irq_o); // R7

endmodule

// File: rtl/mctr_rdmux.sv
// Module: CSR read selection. It returns the addressed counter half, the
// inhibit value with its reserved bits at zero, or a compare half, and zero
// for every other address. Combinational. Assumes XLEN is at least 3.
module mctr_rdmux #(
    parameter int XLEN = 32,
    parameter int NCNT = 3
) (
    input  logic [11:0]               csr_addr,
    input  logic [NCNT-1:0][XLEN-1:0] cnt_lo_i,
    input  logic [NCNT-1:0][XLEN-1:0] cnt_hi_i,
    input  logic                      inh_cyc_i,
    input  logic                      inh_ret_i,
    input  logic [XLEN-1:0]           cmp_lo_i,
    input  logic [XLEN-1:0]           cmp_hi_i,
    output logic [XLEN-1:0]           rdata_o
);
    import mctr_pkg::*;

    logic [XLEN-1:0] inh_view;

    // Present the inhibit register with every other bit forced to zero.
    always_comb begin
        inh_view = '0;
        inh_view[INH_CYC_BIT] = inh_cyc_i;
        inh_view[INH_RET_BIT] = inh_ret_i;
    end

    // Address decode: the default is zero, and one source wins per address.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (csr_addr == CSR_LO_BASE + 12'(i)) rdata_o = cnt_lo_i[i];
            if (csr_addr == CSR_HI_BASE + 12'(i)) rdata_o = cnt_hi_i[i];
        end
        if (csr_addr == CSR_INH)    rdata_o = inh_view;
        if (csr_addr == CSR_CMP_LO) rdata_o = cmp_lo_i;
        if (csr_addr == CSR_CMP_HI) rdata_o = cmp_hi_i;
    end

endmodule

// File: rtl/mctr_unit.sv
// Module: top of the machine counter unit. It holds the cycle, time and
// retired-instruction counters, the inhibit and compare registers, the CSR
// read port and the timer interrupt. Assumes one core clock, a synchronous
// active-low reset, and a retire pulse of at most one per cycle.
module mctr_unit #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_we,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            retire_i,
    output logic            timer_irq_o
);
    import mctr_pkg::*;

    localparam int CW = 2 * XLEN;

    logic                      inh_cyc;
    logic                      inh_ret;
    logic [XLEN-1:0]           cmp_lo;
    logic [XLEN-1:0]           cmp_hi;
    logic [NCNT-1:0]           cnt_en;
    logic [NCNT-1:0][XLEN-1:0] cnt_lo;
    logic [NCNT-1:0][XLEN-1:0] cnt_hi;

    mctr_regs #(.XLEN(XLEN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_we    (csr_we),
        .inh_cyc_o (inh_cyc),
        .inh_ret_o (inh_ret),
        .cmp_lo_o  (cmp_lo),
        .cmp_hi_o  (cmp_hi)
    );

    // Per-counter enables: cycle and retire obey inhibit, time never stops.
    always_comb begin
        cnt_en          = '0;
        cnt_en[CNT_CYC] = !inh_cyc;
        cnt_en[CNT_TIM] = 1'b1;
        cnt_en[CNT_RET] = retire_i && !inh_ret;
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        mctr_counter #(.XLEN(XLEN)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cnt_en[g]),
            .lo_o  (cnt_lo[g]),
            .hi_o  (cnt_hi[g])
        );
    end

    mctr_rdmux #(.XLEN(XLEN), .NCNT(NCNT)) u_rdmux (
        .csr_addr  (csr_addr),
        .cnt_lo_i  (cnt_lo),
        .cnt_hi_i  (cnt_hi),
        .inh_cyc_i (inh_cyc),
        .inh_ret_i (inh_ret),
        .cmp_lo_i  (cmp_lo),
        .cmp_hi_i  (cmp_hi),
        .rdata_o   (csr_rdata)
    );

    mctr_cmp #(.XLEN(XLEN)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tim_lo_i (cnt_lo[CNT_TIM]),
        .tim_hi_i (cnt_hi[CNT_TIM]),
        .cmp_lo_i (cmp_lo),
        .cmp_hi_i (cmp_hi),
        .irq_o    (timer_irq_o)
    );

    AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        inh_cyc |=> $stable(cnt_lo[CNT_CYC]) && $stable(cnt_hi[CNT_CYC])); // R2

    AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i || inh_ret) |=> $stable(cnt_lo[CNT_RET]) && $stable(cnt_hi[CNT_RET])); // R3

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({cnt_hi[CNT_TIM], cnt_lo[CNT_TIM]}
                          == CW'($past({cnt_hi[CNT_TIM], cnt_lo[CNT_TIM]}) + 1'b1))); // R4

    AST_INH_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == CSR_INH) |-> ((csr_rdata & ~XLEN'(5)) == '0)); // R5

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_is_mapped(csr_addr) |-> (csr_rdata == '0)); // R9

endmodule

// File: tb/mctr_unit_tb.sv
// Testbench: scoreboard. Driver tasks push expected values computed from a
// reference model of the requirements. A monitor pops each item and compares
// it with the design just before the next rising edge.
module mctr_unit_tb;

    localparam int W = 8;
    localparam int CWB = 2 * W;
    localparam time TCLK = 20ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [11:0]    csr_addr = '0;
    logic [W-1:0]   csr_wdata = '0;
    logic           csr_we = 1'b0;
    logic [W-1:0]   csr_rdata;
    logic           retire_i = 1'b0;
    logic           timer_irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [W-1:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    // Reference model state.
    logic [CWB-1:0] m_cyc = '0, m_tim = '0, m_ret = '0, m_cmp = '1;
    logic [W-1:0]   m_inh = '0;

    always #(TCLK/2) clk = ~clk;

    mctr_unit #(.XLEN(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .csr_we      (csr_we),
        .csr_rdata   (csr_rdata),
        .retire_i    (retire_i),
        .timer_irq_o (timer_irq_o)
    );

    // Reference model, updated with the same sampled inputs as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc <= '0; m_tim <= '0; m_ret <= '0; m_cmp <= '1; m_inh <= '0;
        end else begin
            m_tim <= m_tim + 1'b1;
            if (!m_inh[0]) m_cyc <= m_cyc + 1'b1;
            if (retire_i && !m_inh[2]) m_ret <= m_ret + 1'b1;
            if (csr_we) begin
                case (csr_addr)
                    12'h320: m_inh <= csr_wdata & W'(5);
                    12'h321: m_cmp[W-1:0] <= csr_wdata;
                    12'h322: m_cmp[CWB-1:W] <= csr_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [W-1:0] model_read(input logic [11:0] a);
        case (a)
            12'hC00: return m_cyc[W-1:0];
            12'hC80: return m_cyc[CWB-1:W];
            12'hC01: return m_tim[W-1:0];
            12'hC81: return m_tim[CWB-1:W];
            12'hC02: return m_ret[W-1:0];
            12'hC82: return m_ret[CWB-1:W];
            12'h320: return m_inh;
            12'h321: return m_cmp[W-1:0];
            12'h322: return m_cmp[CWB-1:W];
            default: return '0;
        endcase
    endfunction

    task automatic rd(input logic [11:0] a, input string tag);
        item_t it;
        @(negedge clk);
        csr_we = 1'b0; retire_i = 1'b0; csr_addr = a;
        it.is_irq = 1'b0; it.exp = model_read(a); it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic chk_irq(input string tag);
        item_t it;
        @(negedge clk);
        csr_we = 1'b0; retire_i = 1'b0;
        it.is_irq = 1'b1; it.exp = W'(m_tim >= m_cmp); it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wr(input logic [11:0] a, input logic [W-1:0] d);
        @(negedge clk);
        retire_i = 1'b0; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    endtask

    task automatic retire(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            csr_we = 1'b0; retire_i = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            csr_we = 1'b0; retire_i = 1'b0;
        end
    endtask

    // Monitor: compare each queued item a quarter period before the next rising edge.
    always @(negedge clk) begin
        #(TCLK/4);
        while (sbq.size() > 0) begin
            item_t it;
            logic [W-1:0] got;
            it = sbq.pop_front();
            got = it.is_irq ? W'(timer_irq_o) : csr_rdata;
            n_tests++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, got, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(TCLK * 200000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CWB-1:0] tgt;
        // R1: values held under reset
        idle(3);
        rd(12'hC00, "R1 cycle lo in reset");
        rd(12'hC01, "R1 time lo in reset");
        rd(12'hC82, "R1 instret hi in reset");
        rd(12'h320, "R1 inhibit in reset");
        rd(12'h321, "R1 cmp lo in reset");
        rd(12'h322, "R1 cmp hi in reset");
        chk_irq("R1 irq low in reset");
        @(negedge clk); rst_n = 1'b1;
        rd(12'hC01, "R1 time lo first cycle");

        // R2 R4 R3: free counting
        idle(5);
        rd(12'hC00, "R2 cycle lo running");
        rd(12'hC01, "R4 time lo running");
        rd(12'hC02, "R3 instret idle");
        retire(3);
        rd(12'hC02, "R3 instret after 3 pulses");

        // R5 R10: inhibit all
        wr(12'h320, '1);
        rd(12'h320, "R5 inhibit reads 0x5");
        rd(12'hC00, "R10 cycle after inhibit write");
        idle(4);
        rd(12'hC00, "R2 cycle frozen");
        rd(12'hC01, "R4 time ignores inhibit");
        retire(2);
        rd(12'hC02, "R3 instret frozen");

        // R3: only cycle inhibited
        wr(12'h320, W'(1));
        retire(4);
        rd(12'hC02, "R3 instret counts with bit0 only");
        rd(12'hC00, "R2 cycle still frozen");
        wr(12'h320, W'(0));
        idle(2);
        rd(12'hC00, "R2 cycle resumes");

        // R9: unmapped and read-only addresses
        wr(12'h123, 8'hAA);
        rd(12'h123, "R9 unmapped read zero");
        rd(12'h7FF, "R9 unmapped read zero 2");
        wr(12'hC01, 8'h00);
        wr(12'hC80, 8'h55);
        rd(12'hC01, "R9 time unaffected by write");
        rd(12'hC80, "R9 cycle hi unaffected by write");
        rd(12'h320, "R9 inhibit intact");

        // R8: carry into high halves
        idle(300);
        rd(12'hC00, "R8 cycle lo after wrap");
        rd(12'hC80, "R8 cycle hi after wrap");
        rd(12'hC01, "R8 time lo after wrap");
        rd(12'hC81, "R8 time hi after wrap");

        // R6 R7: compare, low half first
        @(negedge clk);
        tgt = m_tim + CWB'(30);
        wr(12'h321, tgt[W-1:0]);
        chk_irq("R7 irq low with hi still all ones");
        wr(12'h322, tgt[CWB-1:W]);
        rd(12'h321, "R6 cmp lo readback");
        rd(12'h322, "R6 cmp hi readback");
        for (int i = 0; i < 40; i++) begin
            chk_irq("R7 irq across compare point");
        end
        rd(12'hC81, "R7 time hi after match");
        wr(12'h322, '1);
        chk_irq("R7 irq drops when compare raised");

        idle(3);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule